// File: doc/BRIEF.md
# Dirty Page Write-Back Tracker

This block sits beside a working copy of a memory that is mirrored into a slower backing store. It watches the byte addresses of writes into the working copy and remembers which single page holds changes that have not yet been saved. It asks for a write-back of a page only when needed. That happens when a write lands in a different page from the one being tracked, or when an explicit flush arrives. A flush is typically raised when a transaction ends or when state is about to be captured.

The write, flush and write-back paths are valid/ready channels. A write or flush is taken in the cycle where its valid and ready are both high. The write-back request is a one-entry output channel. Once `wb_valid` rises, it and `wb_page` hold until the cycle where `wb_ready` is high, and it drops in the following cycle. While that request waits, the tracker cannot take any event that would create a second request. It holds such an event off with its ready. Writes that stay inside the tracked page, and the first write after an empty state, still flow through. When a write and a flush are offered together, the write goes first.

`dirty_valid` and `dirty_page` show the tracked page at all times. When nothing is tracked, `dirty_valid` is low and `dirty_page` reads zero, so the empty state is a separate encoding and not a page number.

Top module: `dirty_page_tracker`

## Requirements
- R1: The page index of a write is its byte address shifted right by log2(PAGE_BYTES), where PAGE_BYTES defaults to 256.
- R2: After reset `dirty_valid` is 0, `dirty_page` is 0, `wb_valid` is 0, and both `wr_ready` and `flush_ready` are 1.
- R3: A write accepted while a different page is tracked raises `wb_valid` in the next cycle, with `wb_page` equal to the previously tracked page.
- R4: In the cycle after any accepted write, `dirty_valid` is 1 and `dirty_page` equals the written page.
- R5: A flush accepted while a page is tracked raises `wb_valid` in the next cycle with that page on `wb_page`. From that cycle on, `dirty_valid` is 0 and `dirty_page` is 0.
- R6: A flush accepted with nothing tracked produces no request, and the tracker stays empty.
- R7: A write accepted into the page already tracked produces no request.
- R8: While `wb_valid` is high and `wb_ready` is low, `wb_valid` and `wb_page` hold. `wb_valid` is low in the cycle after the handshake, unless a new request is loaded in that same cycle.
- R9: While a request is pending, a write to a page other than the tracked one sees `wr_ready` low and changes nothing. A write into the tracked page is still accepted.
- R10: `flush_ready` is low while `wr_valid` is high. It is also low while a request is pending and a page is tracked.
- R11: The first write after an empty state produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A write into the working copy is offered |
| wr_ready | output | 1 | The tracker can take the offered write |
| wr_addr | input | ADDR_W | Byte address of the write |
| flush_valid | input | 1 | A flush is offered |
| flush_ready | output | 1 | The tracker can take the offered flush |
| wb_valid | output | 1 | Write-back request pending |
| wb_ready | input | 1 | Backing store takes the request |
| wb_page | output | ADDR_W-log2(PAGE_BYTES) | Page index to write back |
| dirty_valid | output | 1 | A page holds unsaved writes |
| dirty_page | output | ADDR_W-log2(PAGE_BYTES) | Tracked page index, zero when empty |

## Verification
The bench builds the tracker with a 12-bit address and 16-byte pages. With these values a page boundary is crossed within a few addresses, and the last address 0xFFF maps to the all-ones page index 0xFF. That address shows that the top page cannot be mistaken for the empty state. The small page also lets the bench hold a write-back unacknowledged across several cycles, while it offers a crossing write, a same-page write and a flush. It can then check each ready decision and confirm that the request holds steady.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  // Kind of event the tracker commits in a cycle.
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_WRITE = 2'd1,
    EV_FLUSH = 2'd2
  } dpt_event_e;

  function automatic int unsigned log2_exact(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return r;
  endfunction

endpackage

// File: rtl/dpt_page_calc.sv
module dpt_page_calc #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_SHIFT = dpt_pkg::log2_exact(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              track_vld,
  input  logic [PAGE_W-1:0] track_page,
  output logic [PAGE_W-1:0] page,
  output logic              crosses
);

  generate
    if (PAGE_SHIFT == 0) begin : g_byte_pages
      assign page = addr;
    end else begin : g_shift_pages
      logic [ADDR_W-1:0] shifted;
      assign shifted = addr >> PAGE_SHIFT;
      assign page    = shifted[PAGE_W-1:0];
    end
  endgenerate

  // A write forces a write-back only if another page is being tracked.
  assign crosses = track_vld && (page != track_page);

  initial begin
    a_r1_page_pow2: assert ((32'd1 << PAGE_SHIFT) == PAGE_BYTES)
      else $error("PAGE_BYTES must be a power of two");
  end

endmodule

// File: rtl/dpt_dirty_reg.sv
module dpt_dirty_reg #(
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpt_pkg::dpt_event_e ev,
  input  logic [PAGE_W-1:0] new_page,
  output logic              vld,
  output logic [PAGE_W-1:0] page
);
  import dpt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      page <= '0;
    end else begin
      unique case (ev)
        EV_WRITE: begin
          vld  <= 1'b1;
          page <= new_page;
        end
        EV_FLUSH: begin
          vld  <= 1'b0;
          page <= '0;
        end
        default: ;
      endcase
    end
  end

  // R4: a committed write leaves its page tracked.
  a_r4_write_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_WRITE |=> vld && page == $past(new_page));

  // R5: a committed flush empties the tracker.
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    ev == EV_FLUSH |=> !vld && page == '0);

endmodule

// File: rtl/dpt_wb_req.sv
module dpt_wb_req #(
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] load_page,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [PAGE_W-1:0] wb_page
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_page  <= '0;
    end else if (load) begin
      wb_valid <= 1'b1;
      wb_page  <= load_page;
    end else if (wb_valid && wb_ready) begin
      wb_valid <= 1'b0;
    end
  end

  // R8: a waiting request holds its page.
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_page));

  // R8: a handshake without a new load retires the request.
  a_r8_retire: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && wb_ready && !load |=> !wb_valid);

  // R9/R10: the block never overwrites a request that is still pending.
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wb_valid);

endmodule

// File: rtl/dirty_page_tracker.sv
module dirty_page_tracker #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_BYTES = 256,
  localparam int PAGE_SHIFT = dpt_pkg::log2_exact(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              flush_valid,
  output logic              flush_ready,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [PAGE_W-1:0] wb_page,
  output logic              dirty_valid,
  output logic [PAGE_W-1:0] dirty_page
);
  import dpt_pkg::*;

  logic [PAGE_W-1:0] wr_page;
  logic              crosses;
  logic              wr_fire;
  logic              flush_fire;
  logic              req_load;
  logic [PAGE_W-1:0] req_page;
  dpt_event_e        ev;

  dpt_page_calc #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_page (
    .addr       (wr_addr),
    .track_vld  (dirty_valid),
    .track_page (dirty_page),
    .page       (wr_page),
    .crosses    (crosses)
  );

  // A write is held back only when it needs a second request slot.
  assign wr_ready    = !(wb_valid && crosses);
  // Writes take precedence over flushes offered in the same cycle.
  assign flush_ready = !wr_valid && !(wb_valid && dirty_valid);

  assign wr_fire    = wr_valid && wr_ready;
  assign flush_fire = flush_valid && flush_ready;

  always_comb begin
    ev = EV_IDLE;
    if (wr_fire)         ev = EV_WRITE;
    else if (flush_fire) ev = EV_FLUSH;
  end

  // The page that leaves is always the one tracked before this event.
  assign req_load = (wr_fire && crosses) || (flush_fire && dirty_valid);
  assign req_page = dirty_page;

  dpt_dirty_reg #(
    .PAGE_W   (PAGE_W)
  ) u_dirty (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .new_page (wr_page),
    .vld      (dirty_valid),
    .page     (dirty_page)
  );

  dpt_wb_req #(
    .PAGE_W    (PAGE_W)
  ) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_load),
    .load_page (req_page),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_page   (wb_page)
  );

  // R3: crossing into a new page requests the old one.
  a_r3_cross_requests: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && crosses |=> wb_valid && wb_page == $past(dirty_page));

  // R5: flushing a tracked page requests it.
  a_r5_flush_requests: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire && dirty_valid |=> wb_valid && wb_page == $past(dirty_page));

  // R6: an empty flush is silent.
  a_r6_empty_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire && !dirty_valid && !wb_valid |=> !wb_valid && !dirty_valid);

  // R7 / R11: a write that does not leave the tracked page is silent.
  a_r7_same_page_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !crosses && !wb_valid |=> !wb_valid);

  // R10: a flush is never taken together with a write.
  a_r10_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_fire && flush_fire));

endmodule

// File: tb/dirty_page_tracker_tb.sv
module dirty_page_tracker_tb;

  localparam int ADDR_W     = 12;
  localparam int PAGE_BYTES = 16;
  localparam int PAGE_W     = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic              flush_valid = 1'b0;
  logic              flush_ready;
  logic              wb_valid;
  logic              wb_ready = 1'b0;
  logic [PAGE_W-1:0] wb_page;
  logic              dirty_valid;
  logic [PAGE_W-1:0] dirty_page;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  dirty_page_tracker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .wr_addr     (wr_addr),
    .flush_valid (flush_valid),
    .flush_ready (flush_ready),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_page     (wb_page),
    .dirty_valid (dirty_valid),
    .dirty_page  (dirty_page)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    #1;
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_valid = 1'b1;
    #1;
    while (!flush_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    flush_valid = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    wb_ready = 1'b1;
    @(posedge clk);
    #1;
    wb_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(dirty_valid, 0, "R2 dirty_valid");
    chk(dirty_page, 0, "R2 dirty_page");
    chk(wb_valid, 0, "R2 wb_valid");
    chk(wr_ready, 1, "R2 wr_ready");
    chk(flush_ready, 1, "R2 flush_ready");
  endtask

  task automatic t_first_and_same();
    do_write(12'h123);
    chk(wb_valid, 0, "R11 first write silent");
    chk(dirty_valid, 1, "R4 tracked");
    chk(dirty_page, 'h12, "R1 R4 page of 0x123");
    do_write(12'h12F);
    chk(wb_valid, 0, "R7 same page 0x12F");
    do_write(12'h120);
    chk(wb_valid, 0, "R7 same page 0x120");
    chk(dirty_page, 'h12, "R7 page unchanged");
  endtask

  task automatic t_cross_and_stall();
    do_write(12'h345);
    chk(wb_valid, 1, "R3 request raised");
    chk(wb_page, 'h12, "R3 old page requested");
    chk(dirty_page, 'h34, "R4 new page tracked");
    // offer a crossing write while the request waits
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 12'h500;
    #1;
    chk(wr_ready, 0, "R9 crossing write stalled");
    chk(flush_ready, 0, "R10 flush blocked by write");
    repeat (3) @(posedge clk);
    #1;
    chk(wb_valid, 1, "R8 request held");
    chk(wb_page, 'h12, "R8 page held");
    chk(dirty_page, 'h34, "R9 stalled write no effect");
    wr_valid = 1'b0;
    #1;
    chk(flush_ready, 0, "R10 flush blocked while pending");
    // same-page write still flows
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 12'h34A;
    #1;
    chk(wr_ready, 1, "R9 same page accepted");
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    chk(wb_page, 'h12, "R8 page held after same-page write");
    do_ack();
    chk(wb_valid, 0, "R8 retired after handshake");
    do_write(12'h500);
    chk(wb_valid, 1, "R3 second request");
    chk(wb_page, 'h34, "R3 second old page");
    chk(dirty_page, 'h50, "R4 page 0x50");
    do_ack();
  endtask

  task automatic t_flush();
    do_flush();
    chk(wb_valid, 1, "R5 flush request");
    chk(wb_page, 'h50, "R5 flushed page");
    chk(dirty_valid, 0, "R5 emptied");
    chk(dirty_page, 0, "R5 page reads zero");
    do_ack();
    do_flush();
    chk(wb_valid, 0, "R6 empty flush silent");
    chk(dirty_valid, 0, "R6 still empty");
  endtask

  task automatic t_priority();
    @(negedge clk);
    wr_valid    = 1'b1;
    wr_addr     = 12'h0A0;
    flush_valid = 1'b1;
    #1;
    chk(flush_ready, 0, "R10 write wins");
    chk(wr_ready, 1, "R10 write ready");
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    chk(dirty_page, 'h0A, "R10 write taken first");
    chk(wb_valid, 0, "R11 no request yet");
    @(posedge clk);
    #1;
    flush_valid = 1'b0;
    chk(wb_valid, 1, "R10 flush follows");
    chk(wb_page, 'h0A, "R10 flushed page");
    chk(dirty_valid, 0, "R5 empty after flush");
    do_ack();
  endtask

  task automatic t_top_page();
    do_write(12'hFFF);
    chk(dirty_valid, 1, "R1 top page tracked");
    chk(dirty_page, 'hFF, "R1 page of 0xFFF");
    do_write(12'h000);
    chk(wb_page, 'hFF, "R3 top page requested");
    chk(dirty_page, 'h00, "R1 page of 0x000");
    do_ack();
  endtask

  initial begin
    #20;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_first_and_same();
    t_cross_and_stall();
    t_flush();
    t_priority();
    t_top_page();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule